// File: doc/BRIEF.md
# Head Stepper Phase Decoder

This block sits behind a drive-control output port and turns writes to that port into head movement. The two lowest bits of the port's output register carry a stepper-motor phase. Each time software writes the port while both phase pins are configured as outputs, the block compares the new phase with the one it saw last. It then emits a single-clock pulse that moves the head half a track inward or outward, or no pulse at all.

A saturating half-track position counter follows those pulses and is exposed as an output. The same port also carries a spindle motor enable and an activity LED. Each of these is asserted only when its output bit is set and its direction bit marks it as an output.

Top module: `head_phase_decoder`

## Requirements
- R1: A phase evaluation happens only on a clock edge where `port_wr` is 1 and `port_dir[1:0]` equals 2'b11. Any other write produces no step pulse and leaves the stored phase unchanged.
- R2: When (`port_out[1:0]` minus the stored phase) modulo 4 equals 1, `step_up` is 1 for exactly the one clock cycle that follows the evaluating edge.
- R3: When that modulo-4 difference equals 3, `step_down` is 1 for exactly the one clock cycle that follows the evaluating edge.
- R4: A difference of 0 or 2 produces no pulse. `step_up` and `step_down` are never 1 together.
- R5: Every evaluation stores `port_out[1:0]` as the new previous phase. The stored phase is 0 after reset.
- R6: `half_track` goes up by 1 with each `step_up` and down by 1 with each `step_down`, and becomes visible in the same cycle as the pulse. Otherwise it holds its value.
- R7: `half_track` saturates at 0 and at TRACK_MAX (default 83). A step past a limit still produces its pulse but leaves the counter unchanged.
- R8: After reset, `half_track` is TRACK_INIT (default 0) and both step pulses are 0.
- R9: `motor_on` is 1 exactly when `port_out[2]` and `port_dir[2]` are both 1. With the default AUX_REG=0 it follows the inputs combinationally; with AUX_REG=1 it lags them by one clock.
- R10: `led_on` is 1 exactly when `port_out[3]` and `port_dir[3]` are both 1, with the same timing rule as `motor_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_out | input | PORT_W | Contents of the drive-control output register |
| port_dir | input | PORT_W | Direction register, where 1 marks a pin as an output |
| port_wr | input | 1 | One-cycle strobe, high when the output register was written |
| step_up | output | 1 | One-cycle pulse that moves the head half a track up |
| step_down | output | 1 | One-cycle pulse that moves the head half a track down |
| motor_on | output | 1 | Spindle motor enable |
| led_on | output | 1 | Activity LED |
| half_track | output | $clog2(TRACK_MAX+1) | Saturating half-track position |

## Verification
The assertions assume that `port_out`, `port_dir` and `port_wr` are synchronous to `clk` and are free of X after reset. They also assume that the parameters satisfy the elaboration checks, so the pulse-to-counter relations only have to hold for a legal TRACK_MAX. The stimulus changes every input on the falling edge and holds the strobe high for exactly one rising edge. It samples outputs on the falling edge after that, so each write is evaluated exactly once and its pulse is observed in a well-defined cycle.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
   localparam int PHASE_W   = 2;
   localparam int MOTOR_BIT = 2;
   localparam int LED_BIT   = 3;

   typedef enum logic [1:0] {
      MOVE_NONE = 2'b00,
      MOVE_UP   = 2'b01,
      MOVE_DOWN = 2'b10
   } move_e;

   function automatic move_e classify(input logic [PHASE_W-1:0] delta);
      if (delta == PHASE_W'(1))
         return MOVE_UP;
      else if (delta == {PHASE_W{1'b1}})
         return MOVE_DOWN;
      else
         return MOVE_NONE;
   endfunction
endpackage

// File: rtl/hpd_phase_tracker.sv
module hpd_phase_tracker
   import hpd_pkg::*;
#(
   parameter int PW = PHASE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          eval_en,
   input  logic [PW-1:0] phase_new,
   output logic          pulse_up,
   output logic          pulse_down
);
   logic [PW-1:0] phase_last;
   logic [PW-1:0] delta;
   move_e         move;

   // wrap-around subtraction gives the modulo-2^PW difference
   assign delta = phase_new - phase_last;
   assign move  = classify(delta);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_last <= '0;
         pulse_up   <= 1'b0;
         pulse_down <= 1'b0;
      end else begin
         pulse_up   <= eval_en && (move == MOVE_UP);
         pulse_down <= eval_en && (move == MOVE_DOWN);
         if (eval_en)
            phase_last <= phase_new;
      end
   end
endmodule

// File: rtl/hpd_track_counter.sv
module hpd_track_counter #(
   parameter int LIMIT = 83,
   parameter int INIT  = 0,
   parameter int W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP  = W'(LIMIT);
   localparam logic [W-1:0] BASE = W'(INIT);

   logic at_top;
   logic at_floor;

   assign at_top   = (count == TOP);
   assign at_floor = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= BASE;
      else if (inc && !dec && !at_top)
         count <= count + W'(1);
      else if (dec && !inc && !at_floor)
         count <= count - W'(1);
   end
endmodule

// File: rtl/hpd_aux_decode.sv
module hpd_aux_decode #(
   parameter int PORT_W  = 8,
   parameter int M_BIT   = 2,
   parameter int L_BIT   = 3,
   parameter bit AUX_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] dout,
   input  logic [PORT_W-1:0] ddir,
   output logic              motor,
   output logic              led
);
   logic [PORT_W-1:0] driven;
   assign driven = dout & ddir;

   generate
      if (AUX_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               motor <= 1'b0;
               led   <= 1'b0;
            end else begin
               motor <= driven[M_BIT];
               led   <= driven[L_BIT];
            end
         end
      end else begin : g_comb
         assign motor = driven[M_BIT];
         assign led   = driven[L_BIT];
      end
   endgenerate
endmodule

// File: rtl/head_phase_decoder.sv
module head_phase_decoder
   import hpd_pkg::*;
#(
   parameter int PORT_W     = 8,
   parameter int TRACK_MAX  = 83,
   parameter int TRACK_INIT = 0,
   parameter bit AUX_REG    = 1'b0,
   localparam int TRACK_W   = $clog2(TRACK_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PORT_W-1:0]  port_out,
   input  logic [PORT_W-1:0]  port_dir,
   input  logic               port_wr,
   output logic               step_up,
   output logic               step_down,
   output logic               motor_on,
   output logic               led_on,
   output logic [TRACK_W-1:0] half_track
);
   generate
      if (PORT_W <= LED_BIT) begin : g_bad_port
         $error("PORT_W must cover the LED bit");
      end
      if (TRACK_MAX < 1) begin : g_bad_max
         $error("TRACK_MAX must be at least 1");
      end
      if (TRACK_INIT < 0 || TRACK_INIT > TRACK_MAX) begin : g_bad_init
         $error("TRACK_INIT must lie within 0..TRACK_MAX");
      end
   endgenerate

   logic phase_pins_out;
   logic eval_en;

   assign phase_pins_out = &port_dir[PHASE_W-1:0];
   assign eval_en        = port_wr && phase_pins_out;

   hpd_phase_tracker #(.PW(PHASE_W)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .eval_en    (eval_en),
      .phase_new  (port_out[PHASE_W-1:0]),
      .pulse_up   (step_up),
      .pulse_down (step_down)
   );

   // the counter and the pulses are updated on the same clock edge
   logic cnt_inc;
   logic cnt_dec;
   assign cnt_inc = eval_en && (classify(port_out[PHASE_W-1:0] - u_phase.phase_last) == MOVE_UP);
   assign cnt_dec = eval_en && (classify(port_out[PHASE_W-1:0] - u_phase.phase_last) == MOVE_DOWN);

   hpd_track_counter #(.LIMIT(TRACK_MAX), .INIT(TRACK_INIT), .W(TRACK_W)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc),
      .dec   (cnt_dec),
      .count (half_track)
   );

   hpd_aux_decode #(
      .PORT_W  (PORT_W),
      .M_BIT   (MOTOR_BIT),
      .L_BIT   (LED_BIT),
      .AUX_REG (AUX_REG)
   ) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .dout  (port_out),
      .ddir  (port_dir),
      .motor (motor_on),
      .led   (led_on)
   );
endmodule

// File: rtl/head_phase_decoder_chk.sv
module head_phase_decoder_chk #(
   parameter int PORT_W    = 8,
   parameter int TRACK_MAX = 83,
   parameter bit AUX_REG   = 1'b0,
   parameter int TRACK_W   = $clog2(TRACK_MAX + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PORT_W-1:0]  port_out,
   input logic [PORT_W-1:0]  port_dir,
   input logic               port_wr,
   input logic               step_up,
   input logic               step_down,
   input logic               motor_on,
   input logic               led_on,
   input logic [TRACK_W-1:0] half_track
);
   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_up && step_down));

   p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr && port_dir[1:0] != 2'b11) |=> (!step_up && !step_down));

   p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_up |-> $past(port_wr && port_dir[1:0] == 2'b11));

   p_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_down |-> $past(port_wr && port_dir[1:0] == 2'b11));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_up && !step_down) |-> $stable(half_track));

   p_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && $past(half_track) != TRACK_W'(TRACK_MAX))
         |-> (half_track == $past(half_track) + TRACK_W'(1)));

   p_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_down && $past(half_track) != '0)
         |-> (half_track == $past(half_track) - TRACK_W'(1)));

   p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      half_track <= TRACK_W'(TRACK_MAX));

   generate
      if (AUX_REG) begin : g_reg
         p_motor_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (motor_on == $past(port_out[2] && port_dir[2])));
         p_led_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (led_on == $past(port_out[3] && port_dir[3])));
      end else begin : g_comb
         p_motor_r9: assert property (@(posedge clk) disable iff (!rst_n)
            motor_on == (port_out[2] && port_dir[2]));
         p_led_r10: assert property (@(posedge clk) disable iff (!rst_n)
            led_on == (port_out[3] && port_dir[3]));
      end
   endgenerate
endmodule

bind head_phase_decoder head_phase_decoder_chk #(
   .PORT_W    (PORT_W),
   .TRACK_MAX (TRACK_MAX),
   .AUX_REG   (AUX_REG),
   .TRACK_W   (TRACK_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .port_out   (port_out),
   .port_dir   (port_dir),
   .port_wr    (port_wr),
   .step_up    (step_up),
   .step_down  (step_down),
   .motor_on   (motor_on),
   .led_on     (led_on),
   .half_track (half_track)
);

// File: tb/sim_head_phase_decoder.sv
module sim_head_phase_decoder;
   localparam int PW    = 8;
   localparam int TMAX  = 83;
   localparam int TW    = $clog2(TMAX + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] port_out = '0;
   logic [PW-1:0] port_dir = '0;
   logic          port_wr = 1'b0;
   logic          step_up;
   logic          step_down;
   logic          motor_on;
   logic          led_on;
   logic [TW-1:0] half_track;

   int n_vec  = 0;
   int n_miss = 0;
   int exp_phase = 0;
   int exp_track = 0;

   always #4 clk = ~clk;

   head_phase_decoder #(.PORT_W(PW), .TRACK_MAX(TMAX)) u0 (
      .clk(clk), .rst_n(rst_n), .port_out(port_out), .port_dir(port_dir),
      .port_wr(port_wr), .step_up(step_up), .step_down(step_down),
      .motor_on(motor_on), .led_on(led_on), .half_track(half_track));

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_miss++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one strobed write; checks pulse, counter, and that the pulse lasts one cycle
   task automatic wr(input int out_v, input int dir_v, input string tag);
      int diff;
      bit ev;
      int eu;
      int ed;
      ev = ((dir_v & 3) == 3);
      diff = ((out_v & 3) - exp_phase + 4) % 4;
      eu = (ev && diff == 1) ? 1 : 0;
      ed = (ev && diff == 3) ? 1 : 0;
      if (ev) exp_phase = out_v & 3;
      if (eu && exp_track < TMAX) exp_track++;
      if (ed && exp_track > 0) exp_track--;
      @(negedge clk);
      port_out = PW'(out_v);
      port_dir = PW'(dir_v);
      port_wr  = 1'b1;
      @(negedge clk);
      port_wr  = 1'b0;
      chk({tag, " up"}, int'(step_up), eu);
      chk({tag, " down"}, int'(step_down), ed);
      chk({tag, " track"}, int'(half_track), exp_track);
      @(negedge clk);
      chk({tag, " up gone"}, int'(step_up), 0);
      chk({tag, " down gone"}, int'(step_down), 0);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_phase = 0;
      exp_track = 0;
      chk("R8 reset track", int'(half_track), 0);
      chk("R8 reset up", int'(step_up), 0);
      chk("R8 reset down", int'(step_down), 0);
      // stored phase is 0: writing 1 must step up (R5)
      wr(1, 3, "R5 reset phase");
   endtask

   task automatic t_up;
      wr(2, 3, "R2 up 1->2");
      wr(3, 3, "R2 up 2->3");
      wr(0, 3, "R2 up wrap 3->0");
      wr(1, 3, "R2 up 0->1");
   endtask

   task automatic t_down;
      wr(0, 3, "R3 down 1->0");
      wr(3, 3, "R3 down wrap 0->3");
      wr(2, 3, "R3 down 3->2");
   endtask

   task automatic t_none;
      wr(2, 3, "R4 same phase");
      wr(0, 3, "R4 diff two");
      wr(2, 3, "R4 diff two back");
      wr(2, 8'hFF, "R4 same all out");
   endtask

   task automatic t_ignore;
      // phase stays 2; ignored writes of 3 then evaluated 3 must step up
      wr(3, 1, "R1 dir01");
      wr(3, 2, "R1 dir10");
      wr(3, 0, "R1 dir00");
      wr(3, 3, "R1 after ignore");
      @(negedge clk);
      port_out = 8'h00;
      port_dir = 8'h03;
      @(negedge clk);
      chk("R1 no strobe up", int'(step_up), 0);
      chk("R1 no strobe down", int'(step_down), 0);
      chk("R1 no strobe track", int'(half_track), exp_track);
      wr(0, 3, "R1 phase kept");
   endtask

   task automatic t_floor;
      while (exp_track > 0) wr((exp_phase + 3) % 4, 3, "R7 descend");
      wr((exp_phase + 3) % 4, 3, "R7 floor");
      wr((exp_phase + 3) % 4, 3, "R7 floor again");
      chk("R7 floor value", int'(half_track), 0);
   endtask

   task automatic t_ceiling;
      for (int i = 0; i < TMAX + 3; i++) wr((exp_phase + 1) % 4, 3, "R6 R7 climb");
      chk("R7 ceiling value", int'(half_track), TMAX);
      wr((exp_phase + 3) % 4, 3, "R6 leave ceiling");
   endtask

   task automatic aux(input int o, input int d, input int em, input int el);
      @(negedge clk);
      port_out = PW'(o);
      port_dir = PW'(d);
      #1;
      chk("R9 motor", int'(motor_on), em);
      chk("R10 led", int'(led_on), el);
   endtask

   task automatic t_aux;
      aux(8'h04, 8'h04, 1, 0);
      aux(8'h04, 8'h00, 0, 0);
      aux(8'h00, 8'h04, 0, 0);
      aux(8'h08, 8'h08, 0, 1);
      aux(8'h08, 8'hF7, 0, 0);
      aux(8'h0C, 8'h0C, 1, 1);
      aux(8'hF3, 8'hFF, 0, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_vec++;
      n_miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   initial begin : main
      t_reset();
      t_up();
      t_down();
      t_none();
      t_ignore();
      t_floor();
      t_ceiling();
      t_aux();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end
endmodule